// File: doc/BRIEF.md
# Indirect-Indexed Codec Control Register File

This block is the control-register front end of an audio codec. A bus master reaches it through a 64-byte window of sixteen 32-bit word slots. Most slots are plain 32-bit storage. Slot 0 holds a pointer, and slot 1 is a data port into a second bank of thirty-two 8-bit codec registers; the pointer is the low five bits of slot 0.

Several codec registers have special access rules. One cannot be read back, two cannot be written, and one keeps fixed version bits. Slot 2 ignores every write. Writing slot 4 with its lowest bit set returns the whole register state to its reset values in the same clock edge.

Reads return their data one clock after the strobe, and the read data holds between reads. The interrupt output is tied inactive.

Top module: `cdc_ctrl_regfile`

## Requirements
- R1: After hardware reset every slot reads zero and every codec register reads zero, except codec register 12, which reads 0x8A, and codec register 25, which reads 0xA0.
- R2: A write stores all 32 bits in slots 0, 3 and 5 to 15, and a read of such a slot returns the stored value. Read data appears on the first clock after the read strobe and holds until the next read.
- R3: A read of slot 1 returns, zero-extended, the codec register selected by bits [4:0] of slot 0. A write to slot 1 stores bits [7:0] of the write data into that codec register.
- R4: Codec register 3 always reads zero through slot 1, even after it has been written.
- R5: Writes through slot 1 to codec registers 11 and 25 have no effect.
- R6: A write to codec register 12 stores (data[7:0] & 0x40) | 0x8A.
- R7: Writes to slot 2 have no effect, and slot 2 reads zero.
- R8: A write to slot 4 with data bit 0 set restores every slot and every codec register to its R1 value on that same edge. Slot 4 then holds data & 0x7F.
- R9: A write to slot 4 with data bit 0 clear stores data & 0x7F and leaves all other state unchanged.
- R10: Only byte-address bits [5:2] select the slot. Bits [1:0] and all bits above bit 5 are ignored.
- R11: The interrupt output stays low at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | One-cycle access strobe |
| bus_we | input | 1 | 1 = write, 0 = read, qualified by bus_valid |
| bus_addr | input | ADDR_W (12) | Byte address; only bits [5:2] are decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid one clock after a read strobe |
| irq | output | 1 | Interrupt request, always low |

## Verification
A wrong pointer, a bad reset value, or a protected codec register that was overwritten stays hidden until it is read back. Through slot 1, each such fault shows up one clock after the next read strobe. The bench therefore follows every write of interest with a read, and sweeps all 32 codec registers after reset.

A software reset that misses part of the state is found by reading back both banks right after the slot-4 write. An aliasing fault in the address decode shows up as a slot read returning a neighbour's value.

// File: rtl/cdc_rf_pkg.sv
// Shared constants for the codec control register file: bank sizes,
// special slot and codec-register indices, fixed bit patterns, and the
// reset value of each codec register. Assumes 16 slots and 32 codec registers.
package cdc_rf_pkg;
    localparam int DATA_W     = 32;
    localparam int DIR_COUNT  = 16;
    localparam int IND_COUNT  = 32;
    localparam int IND_W      = 8;
    localparam int DIR_IDX_W  = $clog2(DIR_COUNT);
    localparam int IND_IDX_W  = $clog2(IND_COUNT);

    // Slot roles
    localparam int SLOT_PTR    = 0;
    localparam int SLOT_PORT   = 1;
    localparam int SLOT_LOCKED = 2;
    localparam int SLOT_CTRL   = 4;

    // Codec register roles
    localparam int CR_NOREAD   = 3;
    localparam int CR_FIXED_A  = 11;
    localparam int CR_VERSION  = 12;
    localparam int CR_FIXED_B  = 25;

    localparam logic [IND_W-1:0]  VER_BITS  = 8'h8A;
    localparam logic [IND_W-1:0]  VER_KEEP  = 8'h40;
    localparam logic [IND_W-1:0]  ID_BITS   = 8'hA0;
    localparam logic [DATA_W-1:0] CTRL_MASK = 32'h0000_007F;

    // Reset value of a codec register by index
    function automatic logic [IND_W-1:0] cr_reset_value(input int idx);
        if (idx == CR_VERSION)      return VER_BITS;
        else if (idx == CR_FIXED_B) return ID_BITS;
        else                        return '0;
    endfunction
endpackage

// File: rtl/cdc_rf_decode.sv
// Address decode for the register window. Turns a bus strobe into a
// one-hot slot write vector, a read strobe, a codec-port write and a
// software-reset pulse. Assumes byte addressing; only bits [DIR_IDX_W+1:2] decode.
module cdc_rf_decode
    import cdc_rf_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                 bus_valid,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 wdata_lsb,
    output logic [DIR_IDX_W-1:0] slot_idx,
    output logic                 rd_stb,
    output logic [DIR_COUNT-1:0] wr_vec,
    output logic                 port_wr,
    output logic                 sw_clr
);
    logic unused_addr_bits;

    // Slot index from the word-address bits only
    assign slot_idx = bus_addr[DIR_IDX_W+1:2];
    assign unused_addr_bits = ^{bus_addr[ADDR_W-1:DIR_IDX_W+2], bus_addr[1:0]};

    // Read strobe qualifies a valid non-write access
    assign rd_stb = bus_valid && !bus_we;

    // One-hot write enables, one per slot
    for (genvar g = 0; g < DIR_COUNT; g++) begin : g_wr
        assign wr_vec[g] = bus_valid && bus_we && (slot_idx == DIR_IDX_W'(g));
    end

    // Codec data port write and software reset request
    assign port_wr = wr_vec[SLOT_PORT];
    assign sw_clr  = wr_vec[SLOT_CTRL] && wdata_lsb;
endmodule

// File: rtl/cdc_rf_direct_bank.sv
// Bank of 32-bit slots. Ordinary slots store the full word. The port
// slot and the locked slot hold no storage. The control slot stores a
// masked value and also loads on the write that triggers a clear.
// Assumes at most one slot write per cycle.
module cdc_rf_direct_bank
    import cdc_rf_pkg::*;
#(
    parameter int N = DIR_COUNT,
    parameter int W = DATA_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic [N-1:0]          wr_vec,
    input  logic [W-1:0]          wdata,
    output logic [N-1:0][W-1:0]   slot_q
);
    for (genvar g = 0; g < N; g++) begin : g_slot
        if (g == SLOT_PORT || g == SLOT_LOCKED) begin : g_none
            // No storage: port slot and write-ignoring slot read as zero
            assign slot_q[g] = '0;
        end else if (g == SLOT_CTRL) begin : g_ctrl
            logic [W-1:0] q;
            // Control slot keeps the masked write, including the reset bit
            always_ff @(posedge clk) begin
                if (!rst_n)         q <= '0;
                else if (wr_vec[g]) q <= wdata & W'(CTRL_MASK);
            end
            assign slot_q[g] = q;
        end else begin : g_plain
            logic [W-1:0] q;
            // Plain slot: clear on any reset, otherwise load the full word
            always_ff @(posedge clk) begin
                if (!rst_n || clr)  q <= '0;
                else if (wr_vec[g]) q <= wdata;
            end
            assign slot_q[g] = q;
        end
    end
endmodule

// File: rtl/cdc_rf_codec_bank.sv
// Bank of 8-bit codec registers reached through the pointer. Registers
// 11 and 25 are constants, register 12 keeps one writable bit over fixed
// version bits, and the rest are plain storage. Assumes the clear and a
// port write never arrive in the same cycle.
module cdc_rf_codec_bank
    import cdc_rf_pkg::*;
#(
    parameter int N  = IND_COUNT,
    parameter int W  = IND_W,
    parameter int IW = IND_IDX_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                wr_en,
    input  logic [IW-1:0]       ptr,
    input  logic [W-1:0]        wbyte,
    output logic [N-1:0][W-1:0] cr_q
);
    for (genvar g = 0; g < N; g++) begin : g_cr
        if (g == CR_FIXED_A || g == CR_FIXED_B) begin : g_const
            // Read-only register: permanently at its reset value
            assign cr_q[g] = W'(cr_reset_value(g));
        end else if (g == CR_VERSION) begin : g_ver
            logic [W-1:0] q;
            // Version register: only the keep bit follows writes
            always_ff @(posedge clk) begin
                if (!rst_n || clr)                    q <= W'(VER_BITS);
                else if (wr_en && ptr == IW'(g))      q <= (wbyte & W'(VER_KEEP)) | W'(VER_BITS);
            end
            assign cr_q[g] = q;
        end else begin : g_plain
            logic [W-1:0] q;
            // Plain codec register: reset value or written byte
            always_ff @(posedge clk) begin
                if (!rst_n || clr)                    q <= W'(cr_reset_value(g));
                else if (wr_en && ptr == IW'(g))      q <= wbyte;
            end
            assign cr_q[g] = q;
        end
    end
endmodule

// File: rtl/cdc_ctrl_regfile.sv
// Top of the codec control register file. Decodes the bus and updates
// both banks. Read data is registered: it is valid one clock after the
// read strobe and holds until the next read. Assumes single-cycle
// strobes with no back-pressure. The interrupt is tied low.
module cdc_ctrl_regfile
    import cdc_rf_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [DIR_IDX_W-1:0]               slot_idx;
    logic                               rd_stb;
    logic [DIR_COUNT-1:0]               wr_vec;
    logic                               port_wr;
    logic                               sw_clr;
    logic [DIR_COUNT-1:0][DATA_W-1:0]   slot_q;
    logic [IND_COUNT-1:0][IND_W-1:0]    cr_q;
    logic [IND_IDX_W-1:0]               ind_ptr;
    logic [DATA_W-1:0]                  rd_next;

    cdc_rf_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_valid (bus_valid),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .wdata_lsb (bus_wdata[0]),
        .slot_idx  (slot_idx),
        .rd_stb    (rd_stb),
        .wr_vec    (wr_vec),
        .port_wr   (port_wr),
        .sw_clr    (sw_clr)
    );

    cdc_rf_direct_bank #(.N(DIR_COUNT), .W(DATA_W)) u_slots (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (sw_clr),
        .wr_vec (wr_vec),
        .wdata  (bus_wdata),
        .slot_q (slot_q)
    );

    // Pointer into the codec bank: low bits of the pointer slot
    assign ind_ptr = slot_q[SLOT_PTR][IND_IDX_W-1:0];

    cdc_rf_codec_bank #(.N(IND_COUNT), .W(IND_W), .IW(IND_IDX_W)) u_codec (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sw_clr),
        .wr_en (port_wr),
        .ptr   (ind_ptr),
        .wbyte (bus_wdata[IND_W-1:0]),
        .cr_q  (cr_q)
    );

    // Read source select: codec port with write-only masking, else slot
    always_comb begin
        if (slot_idx == DIR_IDX_W'(SLOT_PORT)) begin
            if (ind_ptr == IND_IDX_W'(CR_NOREAD)) rd_next = '0;
            else                                  rd_next = DATA_W'(cr_q[ind_ptr]);
        end else begin
            rd_next = slot_q[slot_idx];
        end
    end

    // Registered read data, updated only on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_stb) bus_rdata <= rd_next;
    end

    assign irq = 1'b0;
endmodule

// File: rtl/cdc_ctrl_regfile_chk.sv
// Checker for the codec control register file, bound to the top. It
// watches the bus, the read data and selected codec-bank state.
module cdc_ctrl_regfile_chk
    import cdc_rf_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_valid,
    input logic                 bus_we,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic [IND_IDX_W-1:0] ptr,
    input logic [IND_W-1:0]     cr_ver,
    input logic [IND_W-1:0]     cr_fa,
    input logic [IND_W-1:0]     cr_fb
);
    logic [DIR_IDX_W-1:0] slot;
    logic                 unused_chk;
    assign slot = bus_addr[DIR_IDX_W+1:2];
    assign unused_chk = ^{bus_wdata[DATA_W-1:IND_W], bus_addr[ADDR_W-1:DIR_IDX_W+2], bus_addr[1:0]};

    // R1: hardware reset clears read data and pointer
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (bus_rdata == '0 && ptr == '0));

    // R2: read data holds when no read strobe
    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_we) |=> $stable(bus_rdata));

    // R4: write-only register reads zero
    p_noread_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_we && slot == DIR_IDX_W'(SLOT_PORT) && ptr == IND_IDX_W'(CR_NOREAD))
        |=> bus_rdata == '0);

    // R5: read-only registers ignore writes
    p_ro_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_we && slot == DIR_IDX_W'(SLOT_PORT)
         && (ptr == IND_IDX_W'(CR_FIXED_A) || ptr == IND_IDX_W'(CR_FIXED_B)))
        |=> ($stable(cr_fa) && $stable(cr_fb)));

    // R6: version register keeps fixed bits
    p_ver_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_we && slot == DIR_IDX_W'(SLOT_PORT) && ptr == IND_IDX_W'(CR_VERSION))
        |=> cr_ver == (($past(bus_wdata[IND_W-1:0]) & VER_KEEP) | VER_BITS));

    // R8: software reset restores pointer and version register
    p_sw_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_we && slot == DIR_IDX_W'(SLOT_CTRL) && bus_wdata[0])
        |=> (ptr == '0 && cr_ver == VER_BITS));
endmodule

bind cdc_ctrl_regfile cdc_ctrl_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ptr       (ind_ptr),
    .cr_ver    (cr_q[cdc_rf_pkg::CR_VERSION]),
    .cr_fa     (cr_q[cdc_rf_pkg::CR_FIXED_A]),
    .cr_fb     (cr_q[cdc_rf_pkg::CR_FIXED_B])
);

// File: tb/tb_cdc_ctrl_regfile.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for reset, software reset and read-data hold.
module tb_cdc_ctrl_regfile;
    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #4 clk = ~clk;

    cdc_ctrl_regfile #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct packed {
        logic        we;
        logic [11:0] addr;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 36;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 12'h000, 32'h0000_0005},  // R2 pointer slot full word
        '{1'b0, 12'h000, 32'h0000_0005},  // R2
        '{1'b1, 12'h00C, 32'hDEAD_BEEF},  // R2
        '{1'b0, 12'h00C, 32'hDEAD_BEEF},  // R2
        '{1'b1, 12'h03C, 32'h1234_5678},  // R2
        '{1'b0, 12'h03C, 32'h1234_5678},  // R2
        '{1'b1, 12'h008, 32'hFFFF_FFFF},  // R7 locked slot
        '{1'b0, 12'h008, 32'h0000_0000},  // R7
        '{1'b1, 12'h000, 32'h0000_000C},  // R6 select version register
        '{1'b1, 12'h004, 32'h0000_00FF},  // R6
        '{1'b0, 12'h004, 32'h0000_00CA},  // R6
        '{1'b1, 12'h004, 32'h0000_0000},  // R6
        '{1'b0, 12'h004, 32'h0000_008A},  // R6
        '{1'b1, 12'h000, 32'h0000_0019},  // R5 register 25
        '{1'b1, 12'h004, 32'h0000_0055},  // R5
        '{1'b0, 12'h004, 32'h0000_00A0},  // R5
        '{1'b1, 12'h000, 32'h0000_000B},  // R5 register 11
        '{1'b1, 12'h004, 32'h0000_0077},  // R5
        '{1'b0, 12'h004, 32'h0000_0000},  // R5
        '{1'b1, 12'h000, 32'h0000_0003},  // R4 register 3
        '{1'b1, 12'h004, 32'h0000_0099},  // R4
        '{1'b0, 12'h004, 32'h0000_0000},  // R4
        '{1'b1, 12'h000, 32'h0000_00E7},  // R3 pointer uses low five bits
        '{1'b1, 12'h004, 32'h0000_01AB},  // R3 low byte stored
        '{1'b0, 12'h004, 32'h0000_00AB},  // R3
        '{1'b0, 12'h000, 32'h0000_00E7},  // R2 full pointer word kept
        '{1'b1, 12'h000, 32'h0000_001F},  // R3 last register
        '{1'b1, 12'h004, 32'h0000_003C},  // R3
        '{1'b0, 12'h004, 32'h0000_003C},  // R3
        '{1'b1, 12'h7D4, 32'h0000_A5A5},  // R10 high bits ignored, slot 5
        '{1'b0, 12'h017, 32'h0000_A5A5},  // R10 low bits ignored
        '{1'b1, 12'h010, 32'h0000_00FE},  // R9 control without reset bit
        '{1'b0, 12'h010, 32'h0000_007E},  // R9
        '{1'b0, 12'h00C, 32'hDEAD_BEEF},  // R9 other slot untouched
        '{1'b0, 12'h000, 32'h0000_001F},  // R9 pointer untouched
        '{1'b0, 12'h04C, 32'hDEAD_BEEF}   // R10 alias of slot 3
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] cr_expect(input int i);
        if (i == 12) return 32'h8A;
        if (i == 25) return 32'hA0;
        return 32'h0;
    endfunction

    initial begin
        logic [31:0] got;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: every slot reads zero after reset
        for (int s = 0; s < 16; s++) begin
            bus_rd(12'(s * 4), got);
            check("R1 slot reset", got, 32'h0);
        end
        // R1: codec register reset values through the port
        for (int i = 0; i < 32; i++) begin
            bus_wr(12'h000, 32'(i));
            bus_rd(12'h004, got);
            check("R1 codec reset", got, cr_expect(i));
        end

        // Vector table: R2..R10, irq watched on every step (R11)
        for (int v = 0; v < NV; v++) begin
            if (TBL[v].we) begin
                bus_wr(TBL[v].addr, TBL[v].data);
            end else begin
                bus_rd(TBL[v].addr, got);
                check($sformatf("table step %0d", v), got, TBL[v].data);
            end
            check("R11 irq low", 32'(irq), 32'h0);
        end

        // R2: read data holds across idle cycles and writes
        bus_rd(12'h00C, held);
        repeat (3) @(negedge clk);
        bus_wr(12'h020, 32'h0BAD_F00D);
        check("R2 rdata hold", bus_rdata, held);

        // R8: software reset via control slot
        bus_wr(12'h010, 32'h0000_00C3);
        bus_rd(12'h010, got); check("R8 control keeps masked value", got, 32'h43);
        bus_rd(12'h00C, got); check("R8 slot 3 cleared", got, 32'h0);
        bus_rd(12'h020, got); check("R8 slot 8 cleared", got, 32'h0);
        bus_rd(12'h000, got); check("R8 pointer cleared", got, 32'h0);
        bus_wr(12'h000, 32'h0000_000C);
        bus_rd(12'h004, got); check("R8 version register restored", got, 32'h8A);
        bus_wr(12'h000, 32'h0000_0007);
        bus_rd(12'h004, got); check("R8 codec register cleared", got, 32'h0);
        bus_wr(12'h000, 32'h0000_001F);
        bus_rd(12'h004, got); check("R8 last codec register cleared", got, 32'h0);

        // R1: hardware reset in the middle of a run
        bus_wr(12'h018, 32'h5555_AAAA);
        bus_wr(12'h004, 32'h0000_0011);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        check("R1 rdata after reset", bus_rdata, 32'h0);
        bus_rd(12'h018, got); check("R1 slot 6 after reset", got, 32'h0);
        bus_rd(12'h010, got); check("R1 control after reset", got, 32'h0);
        bus_wr(12'h000, 32'h0000_0019);
        bus_rd(12'h004, got); check("R1 register 25 after reset", got, 32'hA0);
        check("R11 irq low at end", 32'(irq), 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule